// File: doc/BRIEF.md
# Segmented Address Offset Adder

This block moves an address made of two bytes, a segment and an offset within that segment, by a signed step. It adds an 8-bit two's-complement step to the offset byte. When the unsigned offset runs past the top of its range, the segment goes up by one. When it runs below zero, the segment goes down by one. A CPU can use it as its pointer-step unit: the two bytes of a register pair go in, the step comes from the instruction, and the result is written back to the register pair.

The carry into the segment is worked out from the sign of the step and from wrap of the unsigned offset, not from the raw adder carry-out. Signed overflow of the offset byte (for example 0x7F to 0x80) is not a segment event. An input flag can suppress the carry into the segment. The flag has no effect on the offset result.

The outputs are registered, so a result appears one clock edge after its operands are presented. A synchronous, active-high reset clears both outputs.

Top module: `segmented_addr_adder`

## Requirements
- R1: A clock edge with `rst` high sets `data_out` and `seg_out` to 0x00 at that edge.
- R2: On each edge with `rst` low, `data_out` takes the low 8 bits of `data_in` plus the sign-extended `addend`. Examples: 0x10 + 0x02 = 0x12 and 0x10 + 0xFE = 0x0E.
- R3: With `carry_en` high, if a non-negative `addend` (bit 7 = 0) makes the unsigned sum exceed 0xFF, `seg_out` becomes `seg_in` + 1. Example: 0xFE + 0x04 gives data 0x02 and segment 0x01.
- R4: With `carry_en` high, if a negative `addend` (bit 7 = 1) makes the unsigned result fall below 0x00, `seg_out` becomes `seg_in` - 1. Example: 0x10 + 0xEE gives data 0xFE and segment 0xFF from segment 0x00.
- R5: A negative `addend` whose result stays at or above 0x00 leaves `seg_out` equal to `seg_in`, even though the raw 8-bit add produces a carry-out. Example: 0x10 + 0xFE.
- R6: Crossing from 0x7F to 0x80 is not a segment event. Example: 0x7F + 0x7F gives data 0xFE and the segment unchanged.
- R7: The segment wraps modulo 256. Decrementing 0x00 gives 0xFF, and incrementing 0xFF gives 0x00.
- R8: With `carry_en` low, `seg_out` equals `seg_in` of the previous cycle, while `data_out` still follows R2.
- R9: An `addend` of 0x00 never changes the segment.
- R10: Results are registered with a latency of one clock. Feeding `data_out` back into `data_in` with step 0x02 from 0x10 gives 0x12 and then 0x14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| carry_en | input | 1 | Allows the offset wrap to step the segment |
| data_in | input | 8 | Offset byte, unsigned |
| seg_in | input | 8 | Segment byte, unsigned |
| addend | input | 8 | Signed two's-complement step |
| data_out | output | 8 | Registered adjusted offset |
| seg_out | output | 8 | Registered adjusted segment |

## Verification
The offset wrap and the segment wrap can happen in the same cycle. This occurs when the segment is at 0xFF and the offset carries upward, or when the segment is at 0x00 and the offset borrows. The bench forces both cases directly: 0xFF/0xF0 + 0x20 and 0x00/0x05 + 0x80. It expects both bytes to wrap together, giving 0x10/0x00 and 0x85/0xFF. Random operands then go through a behavioural integer model that is compared on every clock, so it also catches coincidences that the directed cases miss.

// File: rtl/seg_step_pkg.sv
package seg_step_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_dir_e;
endpackage

// File: rtl/offset_wrap_detect.sv
module offset_wrap_detect
  import seg_step_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] offset,
  input  logic [DATA_W-1:0] step,
  output logic [DATA_W-1:0] sum,
  output step_dir_e         dir
);
  localparam int EXT_W = DATA_W + 2;

  logic [EXT_W-1:0] ext_offset;
  logic [EXT_W-1:0] ext_step;
  logic [EXT_W-1:0] ext_sum;

  // Zero-extend the offset, sign-extend the step. Then the top bit is an
  // underflow and the next bit is an unsigned overflow.
  assign ext_offset = {2'b00, offset};
  assign ext_step   = {{2{step[DATA_W-1]}}, step};
  assign ext_sum    = ext_offset + ext_step;
  assign sum        = ext_sum[DATA_W-1:0];

  always_comb begin
    if (ext_sum[EXT_W-1])
      dir = STEP_DOWN;
    else if (ext_sum[DATA_W])
      dir = STEP_UP;
    else
      dir = STEP_HOLD;
  end
endmodule

// File: rtl/segment_stepper.sv
module segment_stepper
  import seg_step_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  logic [SEG_W-1:0] seg,
  input  step_dir_e        dir,
  input  logic             enable,
  output logic [SEG_W-1:0] seg_next
);
  localparam logic [SEG_W-1:0] ONE = SEG_W'(1);

  always_comb begin
    seg_next = seg;
    if (enable) begin
      unique case (dir)
        STEP_UP:   seg_next = seg + ONE;
        STEP_DOWN: seg_next = seg - ONE;
        default:   seg_next = seg;
      endcase
    end
  end
endmodule

// File: rtl/segmented_addr_adder.sv
module segmented_addr_adder
  import seg_step_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              carry_en,
  input  logic [DATA_W-1:0] data_in,
  input  logic [SEG_W-1:0]  seg_in,
  input  logic [DATA_W-1:0] addend,
  output logic [DATA_W-1:0] data_out,
  output logic [SEG_W-1:0]  seg_out
);
  logic [DATA_W-1:0] sum_c;
  step_dir_e         dir_c;
  logic [SEG_W-1:0]  seg_c;

  offset_wrap_detect #(.DATA_W(DATA_W)) u_wrap (
    .offset (data_in),
    .step   (addend),
    .sum    (sum_c),
    .dir    (dir_c)
  );

  segment_stepper #(.SEG_W(SEG_W)) u_seg (
    .seg      (seg_in),
    .dir      (dir_c),
    .enable   (carry_en),
    .seg_next (seg_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
      seg_out  <= '0;
    end else begin
      data_out <= sum_c;
      seg_out  <= seg_c;
    end
  end

  // Checks next to the output registers.
  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  a_r1_reset_clears: assert property (@(posedge clk)
    (past_ok && $past(rst)) |-> (data_out == '0 && seg_out == '0));

  a_r2_data_sum: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(rst)) |->
      (data_out == DATA_W'($past(data_in) + $past(addend))));

  a_r8_seg_pass_when_off: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(rst) && !$past(carry_en)) |-> (seg_out == $past(seg_in)));

  a_r9_zero_step_holds: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(rst) && $past(addend) == '0) |-> (seg_out == $past(seg_in)));

  a_r3_up_needs_positive: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(rst) && seg_out == SEG_W'($past(seg_in) + 1'b1))
      |-> !$past(addend[DATA_W-1]));

  a_r4_down_needs_negative: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(rst) && seg_out == SEG_W'($past(seg_in) - 1'b1))
      |-> $past(addend[DATA_W-1]));
endmodule

// File: tb/tb_segmented_addr_adder.sv
`timescale 1ns/1ps
module tb_segmented_addr_adder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       carry_en = 1'b0;
  logic [7:0] data_in = '0;
  logic [7:0] seg_in = '0;
  logic [7:0] addend = '0;
  logic [7:0] data_out;
  logic [7:0] seg_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  segmented_addr_adder dut (
    .clk(clk), .rst(rst), .carry_en(carry_en), .data_in(data_in),
    .seg_in(seg_in), .addend(addend), .data_out(data_out), .seg_out(seg_out)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Drive one operand set, wait for the edge that registers it, and compare
  // against a behavioural integer model.
  task automatic step(bit ce, int d, int s, int a, string req);
    int sa, total, dexp, sexp;
    @(negedge clk);
    carry_en = ce; data_in = 8'(d); seg_in = 8'(s); addend = 8'(a);
    sa = (a >= 128) ? a - 256 : a;
    total = d + sa;
    dexp = ((total % 256) + 256) % 256;
    sexp = s;
    if (ce && total > 255) sexp = s + 1;
    if (ce && total < 0)   sexp = s - 1;
    sexp = ((sexp % 256) + 256) % 256;
    @(negedge clk);
    check({req, " data"}, data_out, dexp);
    check({req, " seg"}, seg_out, sexp);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; carry_en = 1'b1; data_in = 8'h55; seg_in = 8'h66; addend = 8'h11;
    @(negedge clk); @(negedge clk);
    check("R1 reset data", data_out, 0);
    check("R1 reset seg", seg_out, 0);
    rst = 1'b0;

    step(1, 8'h10, 8'h00, 8'h02, "R2");
    step(1, 8'h10, 8'h00, 8'hFE, "R5");
    step(1, 8'h10, 8'h00, 8'hEE, "R4");
    step(1, 8'hFE, 8'h00, 8'h04, "R3");
    step(1, 8'h7F, 8'h00, 8'h7F, "R6");
    step(1, 8'h80, 8'h33, 8'h80, "R4 edge");
    step(1, 8'hFF, 8'h33, 8'h01, "R3 edge");
    step(1, 8'hF0, 8'hFF, 8'h20, "R7 up wrap");
    step(1, 8'h05, 8'h00, 8'h80, "R7 down wrap");
    step(0, 8'hFE, 8'h40, 8'h04, "R8 up off");
    step(0, 8'h01, 8'h40, 8'hF0, "R8 down off");
    step(1, 8'hFF, 8'h90, 8'h00, "R9");
    step(1, 8'h00, 8'h00, 8'h00, "R9 zero");

    // R10: chained write-back
    @(negedge clk);
    carry_en = 1; data_in = 8'h10; seg_in = 8'h00; addend = 8'h02;
    @(negedge clk);
    check("R10 first", data_out, 8'h12);
    data_in = data_out;
    @(negedge clk);
    check("R10 second", data_out, 8'h14);

    // Random sweep through the model (R2/R3/R4/R8)
    for (int i = 0; i < 300; i++)
      step(($urandom % 4) != 0, $urandom % 256, $urandom % 256, $urandom % 256, "R2/R3/R4/R8 rand");

    // Reset again in the middle of traffic
    @(negedge clk);
    rst = 1; data_in = 8'hFE; addend = 8'h04; seg_in = 8'h12;
    @(negedge clk);
    check("R1 mid data", data_out, 0);
    check("R1 mid seg", seg_out, 0);
    rst = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule